// File: doc/BRIEF.md
# Jitter Measurement Serial Framer

This block sends a 10-bit jitter measurement out on one serial pin. It uses a repeating frame of 64 bit slots and sends one bit each time the bit-clock enable is high. Each frame holds two separate samples of the jitter word, each sent most significant bit first. Fixed 1 bits sit at chosen slots in the frame. Because of them, a run of 17 zeros followed by a 1 occurs only at the true frame start. A receiver can therefore find the frame with nothing more than a zero-run counter.

A slot counter walks from 0 to 63 and wraps. At slot 0 the block latches the first sample from the input. At slot 36 it latches the second. All other slots take a fixed value. The output is registered and moves only on an enabled cycle. A synchronous reset puts the counter at slot 47, so a full 17-bit pause comes out before the first start bit.

Top module: `jfs_jitter_framer`

## Requirements
- R1: While `rst` is high at a clock edge, `ser_out` becomes 0 and the slot counter goes to 47. After reset, the first 17 enabled bits are 0 and the 18th is the start bit 1.
- R2: `ser_out` changes only after a rising `clk` edge at which `bit_en` is 1. On other cycles it holds its value.
- R3: Slot 0 (the start bit) and slots 12, 24 and 36 (the marker bits) always send 1.
- R4: Slots 1 to 10 send the word sampled from `jitter_in` at the enabled edge of slot 0. Slot 1 carries bit 9 and slot 10 carries bit 0.
- R5: Slots 37 to 46 send the word sampled from `jitter_in` at the enabled edge of slot 36. Slot 37 carries bit 9 and slot 46 carries bit 0.
- R6: Slots 11, 13 to 23, 25 to 35 and 47 to 63 always send 0.
- R7: The slot counter advances by one on each enabled bit and wraps from 63 to 0, so consecutive start bits are exactly 64 enabled bits apart.
- R8: For every value of the jitter samples, the only 1 in the serial stream that follows at least 17 consecutive 0s is the start bit at slot 0.
- R9: The value of `jitter_in` at any enabled edge other than slots 0 and 36, and at any cycle where `bit_en` is 0, has no effect on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable: one serial bit is sent per high cycle |
| jitter_in | input | 10 | Jitter measurement word, sampled at slots 0 and 36 |
| ser_out | output | 1 | Serial frame output |

## Verification
The assertions assume that `rst` is synchronous and held high for at least one edge before use. They also assume that `bit_en` and `jitter_in` are free of unknown values at every rising edge; any pattern of enables is allowed. The stimulus changes inputs only on the falling edge. It places the chosen sample values at slots 0 and 36 and puts unrelated values on `jitter_in` at every other slot. Across the frames it covers every value of the first sample and runs both a continuous enable and a sparse one.

// File: rtl/jfs_pkg.sv
package jfs_pkg;
    parameter int WORD_W    = 10;
    parameter int FRAME_LEN = 64;
    parameter int PAUSE_LEN = 17;

    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam int IDX_W = $clog2(WORD_W);

    // slot positions in the frame
    localparam int POS_START       = 0;
    localparam int POS_A_FIRST     = POS_START + 1;
    localparam int POS_A_LAST      = POS_A_FIRST + WORD_W - 1;
    localparam int MARK_SPACING    = 12;
    localparam int NUM_MARKS       = 3;
    localparam int POS_CAP_B       = MARK_SPACING * NUM_MARKS;
    localparam int POS_B_FIRST     = POS_CAP_B + 1;
    localparam int POS_B_LAST      = POS_B_FIRST + WORD_W - 1;
    localparam int POS_PAUSE_FIRST = FRAME_LEN - PAUSE_LEN;

    // start bit plus markers at every spacing multiple up to the second capture slot
    function automatic logic [FRAME_LEN-1:0] fixed_ones();
        logic [FRAME_LEN-1:0] m;
        m = '0;
        for (int k = 0; k <= NUM_MARKS; k++) begin
            m[k * MARK_SPACING] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [FRAME_LEN-1:0] FIXED_ONES = fixed_ones();
endpackage

// File: rtl/jfs_frame_ctr.sv
module jfs_frame_ctr
    import jfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    output logic [CNT_W-1:0] slot_q
);
    typedef struct packed {
        logic [CNT_W-1:0] slot;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (int'(st_q.slot) == FRAME_LEN - 1) begin
                st_d.slot = '0;
            end else begin
                st_d.slot = st_q.slot + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.slot <= CNT_W'(POS_PAUSE_FIRST);
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_q = st_q.slot;

    assert_reset_slot_R1: assert property (@(posedge clk)
        rst |=> (int'(slot_q) == POS_PAUSE_FIRST));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_en && int'(slot_q) == FRAME_LEN - 1) |=> (slot_q == '0));

    assert_hold_slot_R7: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(slot_q));
endmodule

// File: rtl/jfs_sample_hold.sv
module jfs_sample_hold
    import jfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [CNT_W-1:0]  slot,
    input  logic [WORD_W-1:0] jitter_in,
    output logic [WORD_W-1:0] samp_a_q,
    output logic [WORD_W-1:0] samp_b_q
);
    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
    } hold_t;

    hold_t st_d, st_q;
    logic  take_a, take_b;

    always_comb begin
        take_a = bit_en && (int'(slot) == POS_START);
        take_b = bit_en && (int'(slot) == POS_CAP_B);
        st_d   = st_q;
        if (take_a) st_d.a = jitter_in;
        if (take_b) st_d.b = jitter_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_a_q = st_q.a;
    assign samp_b_q = st_q.b;

    assert_keep_a_R9: assert property (@(posedge clk) disable iff (rst)
        !(bit_en && slot == '0) |=> $stable(samp_a_q));

    assert_keep_b_R9: assert property (@(posedge clk) disable iff (rst)
        !(bit_en && int'(slot) == POS_CAP_B) |=> $stable(samp_b_q));
endmodule

// File: rtl/jfs_bit_map.sv
module jfs_bit_map
    import jfs_pkg::*;
(
    input  logic [CNT_W-1:0]  slot,
    input  logic [WORD_W-1:0] samp_a,
    input  logic [WORD_W-1:0] samp_b,
    output logic              bit_val
);
    logic [IDX_W-1:0] idx_a, idx_b;
    logic             in_a, in_b;

    always_comb begin
        in_a    = (int'(slot) >= POS_A_FIRST) && (int'(slot) <= POS_A_LAST);
        in_b    = (int'(slot) >= POS_B_FIRST) && (int'(slot) <= POS_B_LAST);
        idx_a   = IDX_W'(POS_A_LAST - int'(slot));
        idx_b   = IDX_W'(POS_B_LAST - int'(slot));
        bit_val = FIXED_ONES[slot];
        if (in_a) bit_val = samp_a[idx_a];
        if (in_b) bit_val = samp_b[idx_b];
    end
endmodule

// File: rtl/jfs_jitter_framer.sv
module jfs_jitter_framer
    import jfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] jitter_in,
    output logic              ser_out
);
    typedef struct packed {
        logic ser;
    } out_t;

    out_t              st_d, st_q;
    logic [CNT_W-1:0]  slot;
    logic [WORD_W-1:0] samp_a, samp_b;
    logic              bit_val;

    jfs_frame_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .slot_q (slot)
    );

    jfs_sample_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .slot      (slot),
        .jitter_in (jitter_in),
        .samp_a_q  (samp_a),
        .samp_b_q  (samp_b)
    );

    jfs_bit_map u_map (
        .slot    (slot),
        .samp_a  (samp_a),
        .samp_b  (samp_b),
        .bit_val (bit_val)
    );

    always_comb begin
        st_d = st_q;
        if (bit_en) st_d.ser = bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.ser;

    assert_reset_out_R1: assert property (@(posedge clk)
        rst |=> !ser_out);

    assert_hold_out_R2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ser_out));

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_en && slot == '0) |=> ser_out);

    assert_marker_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_en && (int'(slot) == MARK_SPACING || int'(slot) == 2 * MARK_SPACING
                    || int'(slot) == POS_CAP_B)) |=> ser_out);

    assert_pause_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_en && int'(slot) >= POS_PAUSE_FIRST) |=> !ser_out);

    assert_msb_a_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_en && int'(slot) == POS_A_FIRST) |=> (ser_out == samp_a[WORD_W-1]));
endmodule

// File: tb/sim_jfs_jitter_framer.sv
module sim_jfs_jitter_framer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [9:0] jitter_in = '0;
    logic       ser_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    int         m_slot;
    logic [9:0] m_a, m_b;
    logic       m_prev;
    int         zero_run;
    int         bits_since_start;
    bit         seen_start;

    always #10 clk = ~clk;

    jfs_jitter_framer u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .jitter_in (jitter_in),
        .ser_out   (ser_out)
    );

    function automatic logic frame_bit(int p, logic [9:0] a, logic [9:0] b);
        if (p == 0 || p == 12 || p == 24 || p == 36) return 1'b1;
        if (p >= 1 && p <= 10) return a[10 - p];
        if (p >= 37 && p <= 46) return b[46 - p];
        return 1'b0;
    endfunction

    function automatic string tag_for(int p);
        if (p == 0 || p == 12 || p == 24 || p == 36) return "R3";
        if (p >= 1 && p <= 10) return "R4 R9";
        if (p >= 37 && p <= 46) return "R5 R9";
        return "R6";
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_slot = 47;
        m_a = '0;
        m_b = '0;
        m_prev = 1'b0;
        zero_run = 0;
        bits_since_start = 0;
        seen_start = 0;
    endtask

    // called at a negedge; returns at the next negedge
    task automatic tick(input logic en, input logic [9:0] j);
        logic e;
        bit_en = en;
        jitter_in = j;
        @(posedge clk);
        #1;
        if (en) begin
            e = frame_bit(m_slot, m_a, m_b);
            if (m_slot == 0) m_a = j;
            if (m_slot == 36) m_b = j;
            check(tag_for(m_slot), ser_out, e);
            bits_since_start++;
            if (ser_out === 1'b1 && zero_run >= 17) begin
                // R8: only slot 0 qualifies
                check_int("R8", m_slot, 0);
                if (seen_start) check_int("R7", bits_since_start, 64);
                else check_int("R1", bits_since_start, 18);
                seen_start = 1;
                bits_since_start = 0;
            end
            zero_run = (ser_out === 1'b0) ? zero_run + 1 : 0;
            m_slot = (m_slot + 1) % 64;
            m_prev = e;
        end else begin
            check("R2", ser_out, m_prev);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_en = 1'b1;
        jitter_in = 10'h3FF;
        @(negedge clk);
        @(negedge clk);
        check("R1", ser_out, 1'b0);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] va, vb, vj;
        model_reset();
        @(negedge clk);
        do_reset();

        // continuous enable; every first-sample value, garbage elsewhere (R9)
        for (int f = 0; f < 1024; f++) begin
            va = 10'(f);
            vb = 10'((f * 37 + 5) & 1023);
            for (int s = 0; s < 64; s++) begin
                if (m_slot == 0) vj = va;
                else if (m_slot == 36) vj = vb;
                else vj = ~(va ^ 10'(s * 13));
                tick(1'b1, vj);
            end
        end

        // reset mid-frame, then sparse enable with random data
        for (int s = 0; s < 20; s++) tick(1'b1, 10'h155);
        do_reset();
        for (int i = 0; i < 1200; i++) begin
            vj = 10'($urandom);
            tick((i % 3) == 0, vj);
        end

        // idle with enable low: output must hold (R2)
        for (int i = 0; i < 30; i++) tick(1'b0, 10'($urandom));

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule